// File: doc/BRIEF.md
# Cartridge Work-RAM Window with Protection Capture

This block sits between a cartridge's CPU bus and its two on-board RAMs. It decodes CPU accesses in the 0x5000–0x7FFF range. The 4 KB region at 0x5000–0x5FFF always goes to an expansion RAM. The 8 KB window at 0x6000–0x7FFF can be steered onto one of four 8 KB pages of a 32 KB battery-backed RAM. When no page is steered there, the access is handed to the program-ROM path. That path lives outside this block, so the block only raises a select for it. The choice of page comes from a mode byte, which the CPU writes through a register decoded in the 0x8000–0xFFFF range.

Some mode values turn the block into a small protection responder. While one of these modes is set, selected writes into the expansion region are copied into three capture latches, and the block becomes armed. While armed, three fixed addresses in the window return the latched bytes instead of RAM. Reading the last of those three addresses disarms the block.

The RAM arrays sit outside the block. It drives their addresses, chip selects and write enables, takes their read data back, and returns one read byte to the CPU. All decoding is combinational. Only the mode byte, the armed flag and the latches are registered. They update on the clock edge that ends a strobed access.

Top module: `cart_ram_window`

## Requirements
- R1: A write whose address satisfies (addr & 0xE001) == 0xA001 loads the data byte into the mode register. This includes aliases such as 0xA003 and 0xBFFF. Writes to any other address at 0x8000 or above leave the mode unchanged.
- R2: Mode bytes 0xE4/0xEC select page 0, 0xE5/0xED page 1, 0xE6/0xEE page 2 and 0xE7/0xEF page 3. For a window access under one of these modes, the block asserts wram_cs_o (and wram_we_o on a write) and drives wram_addr_o = {page, addr[12:0]}. On a read, rdata_o returns wram_rdata_i.
- R3: Under every other mode byte, a window access asserts rom_sel_o, keeps wram_cs_o low and returns rdata_o = 0.
- R4: Any access to 0x5000–0x5FFF asserts xram_cs_o (and xram_we_o on a write) with xram_addr_o = addr[11:0]. On a read, rdata_o returns xram_rdata_i.
- R5: Under mode 0xA1, 0xA5 or 0xA9, a write to 0x5000, 0x5010 or 0x5013 loads capture latch 0, 1 or 2 respectively. Any write to 0x5000–0x5FFF under these modes sets the armed flag. The write still reaches the expansion RAM.
- R6: While armed, a read of 0x6000, 0x6010 or 0x6013 returns latch 0, 1 or 2, whatever the mode. During such a read, neither wram_cs_o nor rom_sel_o is asserted.
- R7: A read of 0x6013 while armed clears the armed flag. Later reads of the three addresses follow R2/R3.
- R8: While armed, every other window address reads exactly as R2/R3 describe.
- R9: After reset the mode byte, the armed flag and all three latches are zero.
- R10: Writes to the expansion region under a mode other than 0xA1/0xA5/0xA9 neither load the latches nor arm the block.
- R11: At most one of xram_cs_o, wram_cs_o and rom_sel_o is high in any cycle. All three are low when no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | Write strobe, one cycle per access |
| cpu_re_i | input | 1 | Read strobe, one cycle per access |
| rdata_o | output | 8 | Read data returned to the CPU |
| xram_cs_o | output | 1 | Expansion RAM select |
| xram_we_o | output | 1 | Expansion RAM write enable |
| xram_addr_o | output | 12 | Expansion RAM address |
| xram_rdata_i | input | 8 | Expansion RAM read data |
| wram_cs_o | output | 1 | Paged RAM select |
| wram_we_o | output | 1 | Paged RAM write enable |
| wram_addr_o | output | 15 | Paged RAM address {page, offset} |
| wram_rdata_i | input | 8 | Paged RAM read data |
| rom_sel_o | output | 1 | Window access handed to the program-ROM path |

## Verification
A corrupted mode register shows up on the very next window access. The page bits of wram_addr_o change, or the access moves between wram_cs_o and rom_sel_o. Sweeping all 256 mode values catches any wrong decode right away. A stuck or spurious armed flag only becomes visible when one of the three capture addresses is read: it then returns a latch byte where RAM data was expected, or the reverse. A bad latch shows up only on the read-back of that particular address. For this reason, the sequence reads back each address in turn, reads again after the disarming read, and arms once through a non-latch address.

// File: rtl/cart_win_pkg.sv
package cart_win_pkg;
  localparam int unsigned N_CAPT = 3;

  // capture/read-back offsets within the 4 KB regions, in latch order
  function automatic logic [11:0] capt_ofs(input int unsigned idx);
    case (idx)
      0:       capt_ofs = 12'h000;
      1:       capt_ofs = 12'h010;
      default: capt_ofs = 12'h013;
    endcase
  endfunction

  localparam logic [15:0] MODE_MASK = 16'hE001;
  localparam logic [15:0] MODE_ADDR = 16'hA001;
endpackage

// File: rtl/cw_mode_decode.sv
module cw_mode_decode #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 2
) (
  input  logic [DATA_W-1:0] mode_i,
  output logic              page_ok_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              capture_o
);
  // paging codes: 1110_x1pp
  assign page_ok_o = (mode_i[7:4] == 4'hE) && mode_i[2];
  assign page_o    = mode_i[PAGE_W-1:0];
  assign capture_o = (mode_i == 8'hA1) || (mode_i == 8'hA5) || (mode_i == 8'hA9);
endmodule

// File: rtl/cw_addr_decode.sv
module cw_addr_decode
  import cart_win_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned N      = N_CAPT
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              xram_hit_o,
  output logic              win_hit_o,
  output logic              mode_hit_o,
  output logic [N-1:0]      capt_wr_hit_o,
  output logic [N-1:0]      capt_rd_hit_o
);
  assign xram_hit_o = (addr_i[15:12] == 4'h5);
  assign win_hit_o  = (addr_i[15:13] == 3'b011);
  assign mode_hit_o = ((addr_i & MODE_MASK) == MODE_ADDR);

  for (genvar g = 0; g < N; g++) begin : g_hit
    assign capt_wr_hit_o[g] = xram_hit_o && (addr_i[11:0] == capt_ofs(g));
    assign capt_rd_hit_o[g] = (addr_i[15:12] == 4'h6) && (addr_i[11:0] == capt_ofs(g));
  end
endmodule

// File: rtl/cw_capture.sv
module cw_capture #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      load_i,
  input  logic              arm_i,
  input  logic              disarm_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      sel_i,
  output logic [DATA_W-1:0] sel_data_o,
  output logic              armed_o
);
  logic [DATA_W-1:0] lat_q [N];

  for (genvar g = 0; g < N; g++) begin : g_lat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        lat_q[g] <= '0;
      else if (load_i[g]) lat_q[g] <= wdata_i;
    end
  end

  // arming write wins over a same-cycle disarm
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_o <= 1'b0;
    else if (arm_i)    armed_o <= 1'b1;
    else if (disarm_i) armed_o <= 1'b0;
  end

  always_comb begin
    sel_data_o = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_i[i]) sel_data_o = lat_q[i];
    end
  end
endmodule

// File: rtl/cart_ram_window.sv
module cart_ram_window
  import cart_win_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned XRAM_AW = 12,
  parameter int unsigned PAGE_AW = 13,
  parameter int unsigned PAGE_W  = 2,
  localparam int unsigned WRAM_AW = PAGE_AW + PAGE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  cpu_addr_i,
  input  logic [DATA_W-1:0]  cpu_wdata_i,
  input  logic               cpu_we_i,
  input  logic               cpu_re_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               xram_cs_o,
  output logic               xram_we_o,
  output logic [XRAM_AW-1:0] xram_addr_o,
  input  logic [DATA_W-1:0]  xram_rdata_i,
  output logic               wram_cs_o,
  output logic               wram_we_o,
  output logic [WRAM_AW-1:0] wram_addr_o,
  input  logic [DATA_W-1:0]  wram_rdata_i,
  output logic               rom_sel_o
);
  logic [DATA_W-1:0] mode_q;
  logic              page_ok, capture, armed;
  logic [PAGE_W-1:0] page;
  logic              xram_hit, win_hit, mode_hit;
  logic [N_CAPT-1:0] wr_hit, rd_hit, capt_sel;
  logic [DATA_W-1:0] capt_data;
  logic              acc, capt_rd, capt_wr;

  cw_addr_decode #(.ADDR_W(ADDR_W), .N(N_CAPT)) u_dec (
    .addr_i        (cpu_addr_i),
    .xram_hit_o    (xram_hit),
    .win_hit_o     (win_hit),
    .mode_hit_o    (mode_hit),
    .capt_wr_hit_o (wr_hit),
    .capt_rd_hit_o (rd_hit)
  );

  cw_mode_decode #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_mode (
    .mode_i    (mode_q),
    .page_ok_o (page_ok),
    .page_o    (page),
    .capture_o (capture)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   mode_q <= '0;
    else if (cpu_we_i && mode_hit) mode_q <= cpu_wdata_i;
  end

  assign acc      = cpu_we_i || cpu_re_i;
  assign capt_wr  = cpu_we_i && capture && xram_hit;
  assign capt_rd  = cpu_re_i && armed && (|rd_hit);
  assign capt_sel = capt_rd ? rd_hit : '0;

  cw_capture #(.DATA_W(DATA_W), .N(N_CAPT)) u_capt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (capt_wr ? wr_hit : '0),
    .arm_i      (capt_wr),
    .disarm_i   (capt_rd && rd_hit[N_CAPT-1]),
    .wdata_i    (cpu_wdata_i),
    .sel_i      (capt_sel),
    .sel_data_o (capt_data),
    .armed_o    (armed)
  );

  assign xram_cs_o   = acc && xram_hit;
  assign xram_we_o   = cpu_we_i && xram_hit;
  assign xram_addr_o = cpu_addr_i[XRAM_AW-1:0];

  assign wram_cs_o   = acc && win_hit && page_ok && !capt_rd;
  assign wram_we_o   = cpu_we_i && win_hit && page_ok;
  assign wram_addr_o = {page, cpu_addr_i[PAGE_AW-1:0]};
  assign rom_sel_o   = acc && win_hit && !page_ok && !capt_rd;

  always_comb begin
    if (capt_rd)                          rdata_o = capt_data;
    else if (cpu_re_i && xram_hit)        rdata_o = xram_rdata_i;
    else if (cpu_re_i && win_hit && page_ok) rdata_o = wram_rdata_i;
    else                                  rdata_o = '0;
  end
endmodule

// File: rtl/cw_checker.sv
module cw_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] cpu_addr_i,
  input logic        cpu_we_i,
  input logic        cpu_re_i,
  input logic        xram_cs_o,
  input logic [11:0] xram_addr_o,
  input logic        wram_cs_o,
  input logic [14:0] wram_addr_o,
  input logic        rom_sel_o,
  input logic        armed,
  input logic [7:0]  mode_q
);
  a_r11_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({xram_cs_o, wram_cs_o, rom_sel_o}));

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_we_i || cpu_re_i) |-> !(xram_cs_o || wram_cs_o || rom_sel_o));

  a_r4_xram_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xram_cs_o |-> (xram_addr_o == cpu_addr_i[11:0]) && (cpu_addr_i[15:12] == 4'h5));

  a_r2_page_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wram_cs_o |-> (wram_addr_o[12:0] == cpu_addr_i[12:0]) && (wram_addr_o[14:13] == mode_q[1:0]));

  a_r1_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_we_i && ((cpu_addr_i & 16'hE001) == 16'hA001)) |=> $stable(mode_q));

  a_r5_arm_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed) |-> $past(cpu_we_i) && ($past(cpu_addr_i[15:12]) == 4'h5));

  a_r7_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && cpu_re_i && !cpu_we_i && cpu_addr_i == 16'h6013) |=> !armed);
endmodule

bind cart_ram_window cw_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_re_i    (cpu_re_i),
  .xram_cs_o   (xram_cs_o),
  .xram_addr_o (xram_addr_o),
  .wram_cs_o   (wram_cs_o),
  .wram_addr_o (wram_addr_o),
  .rom_sel_o   (rom_sel_o),
  .armed       (armed),
  .mode_q      (mode_q)
);

// File: tb/sim_cart_ram_window.sv
`timescale 1ns/1ps
module sim_cart_ram_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  rdata, xram_rd, wram_rd;
  logic        xcs, xwe, wcs, wwe, rsel;
  logic [11:0] xaddr;
  logic [14:0] waddr;

  int unsigned n_chk = 0, n_err = 0;
  logic [7:0]  s_rd;
  logic        s_xcs, s_xwe, s_wcs, s_wwe, s_rom;
  logic [11:0] s_xa;
  logic [14:0] s_wa;

  always #10 clk = ~clk;

  // RAM models: data is an arithmetic function of the RAM address
  assign xram_rd = xaddr[7:0] ^ {4'h0, xaddr[11:8]};
  assign wram_rd = waddr[7:0] ^ {1'b0, waddr[14:8]};

  cart_ram_window u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
    .cpu_we_i(we), .cpu_re_i(re), .rdata_o(rdata),
    .xram_cs_o(xcs), .xram_we_o(xwe), .xram_addr_o(xaddr), .xram_rdata_i(xram_rd),
    .wram_cs_o(wcs), .wram_we_o(wwe), .wram_addr_o(waddr), .wram_rdata_i(wram_rd),
    .rom_sel_o(rsel)
  );

  function automatic logic [7:0] exp_x(input logic [15:0] a);
    return a[7:0] ^ {4'h0, a[11:8]};
  endfunction

  function automatic logic [7:0] exp_w(input logic [1:0] pg, input logic [15:0] a);
    logic [14:0] w;
    w = {pg, a[12:0]};
    return w[7:0] ^ {1'b0, w[14:8]};
  endfunction

  function automatic bit is_paged(input logic [7:0] m);
    return (m[7:4] == 4'hE) && m[2];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic snap();
    s_rd = rdata; s_xcs = xcs; s_xwe = xwe; s_wcs = wcs;
    s_wwe = wwe; s_rom = rsel; s_xa = xaddr; s_wa = waddr;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    #2 snap();
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk); addr = a; re = 1'b1;
    #2 snap();
    @(negedge clk); re = 1'b0;
  endtask

  task automatic chk_paged_rd(input string req, input logic [1:0] pg, input logic [15:0] a);
    rd(a);
    check({req, " wram_cs"}, 32'(s_wcs), 32'd1);
    check({req, " addr"}, 32'(s_wa), 32'({pg, a[12:0]}));
    check({req, " rdata"}, 32'(s_rd), 32'(exp_w(pg, a)));
  endtask

  task automatic chk_latch_rd(input string req, input logic [15:0] a, input logic [7:0] v);
    rd(a);
    check({req, " latch data"}, 32'(s_rd), 32'(v));
    check({req, " no ram/rom"}, 32'({s_wcs, s_rom}), 32'd0);
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R11 idle selects", 32'({xcs, wcs, rsel}), 32'd0);
    rst_n = 1'b1;

    // R9: reset mode is 0 -> window goes to ROM path
    rd(16'h6000);
    check("R9 reset mode rom_sel", 32'(s_rom), 32'd1);
    check("R9 reset mode rdata", 32'(s_rd), 32'd0);
    rd(16'h6013);
    check("R9 not armed after reset", 32'({s_rom, s_rd}), 32'h100);

    // R9: latches reset to zero, arm via a non-latch address
    wr(16'hA001, 8'hA1);
    wr(16'h5100, 8'h99);
    check("R5 xram write passes", 32'({s_xcs, s_xwe, s_xa}), 32'({2'b11, 12'h100}));
    chk_latch_rd("R9 latch0 reset", 16'h6000, 8'h00);
    chk_latch_rd("R9 latch1 reset", 16'h6010, 8'h00);
    chk_latch_rd("R9 latch2 reset", 16'h6013, 8'h00);
    rd(16'h6000);
    check("R7 disarmed to rom", 32'(s_rom), 32'd1);

    // R2/R3: full sweep of the mode byte
    for (int m = 0; m < 256; m++) begin
      wr(16'hA001, 8'(m));
      rd(16'h7123);
      if (is_paged(8'(m))) begin
        check("R2 sweep wram_cs", 32'({s_wcs, s_rom}), 32'h2);
        check("R2 sweep rdata", 32'(s_rd), 32'(exp_w(m[1:0], 16'h7123)));
      end else begin
        check("R3 sweep rom_sel", 32'({s_wcs, s_rom}), 32'h1);
        check("R3 sweep rdata", 32'(s_rd), 32'd0);
      end
    end

    // R2: each paging code over window corners, plus writes
    for (int k = 0; k < 8; k++) begin
      logic [7:0] m;
      m = (k < 4) ? (8'hE4 + 8'(k)) : (8'hEC + 8'(k - 4));
      wr(16'hA001, m);
      chk_paged_rd("R2 low", m[1:0], 16'h6000);
      chk_paged_rd("R2 mid", m[1:0], 16'h6ABC);
      chk_paged_rd("R2 top", m[1:0], 16'h7FFF);
      wr(16'h7456, 8'h5A);
      check("R2 write enable", 32'({s_wcs, s_wwe, s_rom}), 32'h6);
      check("R2 write addr", 32'(s_wa), 32'({m[1:0], 13'h1456}));
    end

    // R1: aliases store, other registers do not
    wr(16'hA001, 8'hE5);
    wr(16'hA000, 8'hE7);
    wr(16'h8001, 8'hE6);
    wr(16'hC001, 8'h00);
    wr(16'hE001, 8'h00);
    chk_paged_rd("R1 non-mode writes ignored", 2'd1, 16'h6100);
    wr(16'hBFFF, 8'hE6);
    chk_paged_rd("R1 alias BFFF", 2'd2, 16'h6100);
    wr(16'hA003, 8'h12);
    rd(16'h6100);
    check("R1 alias A003", 32'(s_rom), 32'd1);

    // R4: expansion region sweep
    for (int a = 16'h5000; a <= 16'h5FFF; a += 16'h0111) begin
      rd(16'(a));
      check("R4 xram cs", 32'({s_xcs, s_xwe, s_wcs, s_rom}), 32'h8);
      check("R4 xram addr", 32'(s_xa), 32'(a[11:0]));
      check("R4 xram rdata", 32'(s_rd), 32'(exp_x(16'(a))));
    end
    wr(16'h5ABC, 8'h11);
    check("R4 xram write", 32'({s_xcs, s_xwe, s_xa}), 32'({2'b11, 12'hABC}));

    // R10: non-capture mode writes do not arm
    wr(16'hA001, 8'hE4);
    wr(16'h5000, 8'h3C);
    wr(16'h5013, 8'h77);
    chk_paged_rd("R10 no arm 6000", 2'd0, 16'h6000);
    chk_paged_rd("R10 no arm 6013", 2'd0, 16'h6013);

    // R5/R6/R7/R8: capture sequence
    wr(16'hA001, 8'hA1);
    wr(16'h5000, 8'h3C);
    check("R5 xram still written", 32'({s_xcs, s_xwe}), 32'h3);
    wr(16'h5010, 8'hC3);
    wr(16'h5013, 8'h77);
    wr(16'hA001, 8'hE6);
    chk_latch_rd("R6 latch1", 16'h6010, 8'hC3);
    chk_latch_rd("R6 latch0", 16'h6000, 8'h3C);
    chk_paged_rd("R8 neighbour 6011", 2'd2, 16'h6011);
    chk_paged_rd("R8 other 7000", 2'd2, 16'h7000);
    chk_latch_rd("R6 latch0 repeat", 16'h6000, 8'h3C);
    chk_latch_rd("R6 latch2", 16'h6013, 8'h77);
    chk_paged_rd("R7 after disarm 6000", 2'd2, 16'h6000);
    chk_paged_rd("R7 after disarm 6013", 2'd2, 16'h6013);

    // R5: arm through a non-latch write under 0xA9, latches keep values
    wr(16'hA001, 8'hA9);
    wr(16'h5800, 8'h44);
    wr(16'hA001, 8'h00);
    chk_latch_rd("R6 unmapped mode latch1", 16'h6010, 8'hC3);
    rd(16'h6001);
    check("R8 unmapped other addr", 32'({s_rom, s_rd}), 32'h100);
    chk_latch_rd("R6 unmapped latch2", 16'h6013, 8'h77);
    rd(16'h6010);
    check("R7 unmapped disarm", 32'(s_rom), 32'd1);

    // R5: mode 0xA5 loads a latch
    wr(16'hA001, 8'hA5);
    wr(16'h5013, 8'hD2);
    chk_latch_rd("R5 mode A5 latch2", 16'h6013, 8'hD2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule